// File: doc/BRIEF.md
# Protocol-Control Status Word Register

This block holds the 16-bit protocol-control word that a sensor tag returns at the front of its identifier memory. Each field in the word has its own owner. The reader may write some fields, subject to the bank write lock. One bit is a constant set at manufacture. Several bits are driven live from the tag's internal state. The three alarm bits are set by the tag's own sensors, and the reader may still overwrite them, for example to clear them while configuring the tag.

The memory front end passes in each reader write aimed at this word, together with the current lock status of the bank. A separate request carries the untraceable operation, together with a flag saying whether the reader has proven the access password. The word is assembled without registers from the stored fields and the live status inputs, so a read always shows the current internal state. The block does not hold the other words of the bank or the lock bits.

Top module: `pc_word_reg`

## Requirements
- R1: While `rst_ni` is low, and immediately after reset, the length field [15:11], the toggle bit 8 and the alarm bits [2:0] read 0.
- R2: Bit 10 always reads 1. In the same cycle, bit 9 follows `xpc_present_i`, bits [7:5] follow `logger_state_i`, bit 4 follows `batt_installed_i` and bit 3 follows `rtc_on_batt_i`.
- R3: When `wr_en_i` is high and `bank_locked_i` is low at a clock edge, `wr_data_i[15:11]`, `wr_data_i[8]` and `wr_data_i[2:0]` are loaded into their fields, and the new values are visible after that edge.
- R4: When `bank_locked_i` is high, a reader write changes none of the length, toggle or alarm bits.
- R5: An unlocked write whose length value is above 13 (5'b01101) leaves the length field unchanged. The toggle and alarm bits of the same write are still applied. The length field never reads above 13.
- R6: When `untrace_en_i` and `acc_priv_i` are both high, `untrace_len_i` is loaded into the length field whether or not the bank is locked. Without `acc_priv_i` the request is ignored. A value above 13 is ignored. If an accepted untraceable request and a reader write arrive in the same cycle, the untraceable length wins.
- R7: Bit 2 is set on a rising edge of (`temp_alarm_a_i` OR `temp_alarm_b_i`). Bit 1 is set on a rising edge of `batt_alarm_i`, and bit 0 on a rising edge of `tamper_alarm_i`. A set bit stays set after its condition drops.
- R8: An unlocked reader write in the same cycle as an alarm's rising edge takes priority, so the written value is stored. An alarm condition that stays high does not set the bit again. Only a later new rising edge does.
- R9: Write data in bits 10, 9 and [7:3] has no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Reader write strobe for this word |
| wr_data_i | input | 16 | Reader write data |
| bank_locked_i | input | 1 | Bank is write-locked |
| untrace_en_i | input | 1 | Untraceable operation request |
| untrace_len_i | input | 5 | Length value carried by the untraceable operation |
| acc_priv_i | input | 1 | Reader holds access-password privilege |
| xpc_present_i | input | 1 | Extended control word is in use |
| logger_state_i | input | 3 | Internal logger state |
| batt_installed_i | input | 1 | Battery is installed |
| rtc_on_batt_i | input | 1 | On-chip RTC is powered by the battery |
| temp_alarm_a_i | input | 1 | First temperature alarm flag |
| temp_alarm_b_i | input | 1 | Second temperature alarm flag |
| batt_alarm_i | input | 1 | Battery alarm flag |
| tamper_alarm_i | input | 1 | Tamper alarm flag |
| pc_word_o | output | 16 | Assembled protocol-control word |

## Verification
Two kinds of event can land on the same edge. A reader write can coincide with a new alarm edge, and an untraceable length update can coincide with a reader write. The bench raises the tamper alarm in the very cycle a clearing write is issued. It then expects the bit to read 0, to stay 0 while the alarm remains high, and to return to 1 only after the alarm falls and rises again. In a second case it drives an untraceable request and a reader write on one edge and expects the untraceable length to win, while the toggle bit still comes from the write.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int LEN_W   = 5;
  localparam int STATE_W = 3;
  localparam int N_ALARM = 3;

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    logic               umi;
    logic               xi;
    logic               tgl;
    logic [STATE_W-1:0] state;
    logic               batt;
    logic               rtc;
    logic [N_ALARM-1:0] alarm;  // [2] temp, [1] battery, [0] tamper
  } pc_word_t;

  localparam int WORD_W = $bits(pc_word_t);
endpackage

// File: rtl/pc_len_field.sv
module pc_len_field #(
  parameter int LEN_W   = 5,
  parameter int LEN_MAX = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ok_i,
  input  logic [LEN_W-1:0] wr_len_i,
  input  logic             ut_ok_i,
  input  logic [LEN_W-1:0] ut_len_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(LEN_MAX);

  logic ut_take, wr_take;
  assign ut_take = ut_ok_i && (ut_len_i <= MaxLen);
  assign wr_take = wr_ok_i && (wr_len_i <= MaxLen);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_o <= '0;
    else if (ut_take) len_o <= ut_len_i;  // untraceable outranks reader write
    else if (wr_take) len_o <= wr_len_i;
  end
endmodule

// File: rtl/pc_alarm_bit.sv
module pc_alarm_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic wr_ok_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      prev_q <= cond_i;
      if (wr_ok_i)                flag_o <= wr_bit_i;  // reader wins same cycle
      else if (cond_i && !prev_q) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pc_word_reg.sv
module pc_word_reg
  import pc_pkg::*;
#(
  parameter int LEN_MAX = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               bank_locked_i,
  input  logic               untrace_en_i,
  input  logic [LEN_W-1:0]   untrace_len_i,
  input  logic               acc_priv_i,
  input  logic               xpc_present_i,
  input  logic [STATE_W-1:0] logger_state_i,
  input  logic               batt_installed_i,
  input  logic               rtc_on_batt_i,
  input  logic               temp_alarm_a_i,
  input  logic               temp_alarm_b_i,
  input  logic               batt_alarm_i,
  input  logic               tamper_alarm_i,
  output logic [WORD_W-1:0]  pc_word_o
);
  pc_word_t           wr_w, rd_w;
  logic               wr_ok, ut_ok;
  logic [LEN_W-1:0]   len_q;
  logic               tgl_q;
  logic [N_ALARM-1:0] alarm_cond, alarm_q;
  logic               unused_wr_bits;

  assign wr_w  = pc_word_t'(wr_data_i);
  assign wr_ok = wr_en_i && !bank_locked_i;
  assign ut_ok = untrace_en_i && acc_priv_i;

  // fixed and computed positions carry no storage
  assign unused_wr_bits = ^{wr_w.umi, wr_w.xi, wr_w.state, wr_w.batt, wr_w.rtc};

  assign alarm_cond = {temp_alarm_a_i | temp_alarm_b_i, batt_alarm_i, tamper_alarm_i};

  pc_len_field #(
    .LEN_W  (LEN_W),
    .LEN_MAX(LEN_MAX)
  ) i_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ok_i (wr_ok),
    .wr_len_i(wr_w.len),
    .ut_ok_i (ut_ok),
    .ut_len_i(untrace_len_i),
    .len_o   (len_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tgl_q <= 1'b0;
    else if (wr_ok) tgl_q <= wr_w.tgl;
  end

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    pc_alarm_bit i_alarm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cond_i  (alarm_cond[g]),
      .wr_ok_i (wr_ok),
      .wr_bit_i(wr_w.alarm[g]),
      .flag_o  (alarm_q[g])
    );
  end

  always_comb begin
    rd_w.len   = len_q;
    rd_w.umi   = 1'b1;
    rd_w.xi    = xpc_present_i;
    rd_w.tgl   = tgl_q;
    rd_w.state = logger_state_i;
    rd_w.batt  = batt_installed_i;
    rd_w.rtc   = rtc_on_batt_i;
    rd_w.alarm = alarm_q;
  end

  assign pc_word_o = rd_w;
endmodule

// File: rtl/pc_word_reg_chk.sv
module pc_word_reg_chk #(
  parameter int LEN_MAX = 13
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic        bank_locked_i,
  input logic        untrace_en_i,
  input logic [4:0]  untrace_len_i,
  input logic        acc_priv_i,
  input logic        tamper_alarm_i,
  input logic [15:0] pc_word_o
);
  localparam logic [4:0] MaxLen = 5'(LEN_MAX);

  AST_LEN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_word_o[15:11] <= MaxLen); // R5

  AST_LOCKED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_locked_i && !(untrace_en_i && acc_priv_i)
    |=> $stable({pc_word_o[15:11], pc_word_o[8]})); // R4

  AST_UNTRACE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    untrace_en_i && acc_priv_i && (untrace_len_i <= MaxLen)
    |=> pc_word_o[15:11] == $past(untrace_len_i)); // R6

  AST_TAMPER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tamper_alarm_i) && !(wr_en_i && !bank_locked_i) |=> pc_word_o[0]); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !bank_locked_i && !wr_data_i[0] |=> !pc_word_o[0]); // R8
endmodule

bind pc_word_reg pc_word_reg_chk #(.LEN_MAX(LEN_MAX)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .bank_locked_i (bank_locked_i),
  .untrace_en_i  (untrace_en_i),
  .untrace_len_i (untrace_len_i),
  .acc_priv_i    (acc_priv_i),
  .tamper_alarm_i(tamper_alarm_i),
  .pc_word_o     (pc_word_o)
);

// File: tb/test_pc_word_reg.sv
`timescale 1ns/1ps
module test_pc_word_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        locked = 1'b0;
  logic        ut_en = 1'b0;
  logic [4:0]  ut_len = '0;
  logic        priv = 1'b0;
  logic        xpc = 1'b0;
  logic [2:0]  state = '0;
  logic        batt = 1'b0;
  logic        rtc = 1'b0;
  logic        ta = 1'b0, tb = 1'b0, ba = 1'b0, tm = 1'b0;
  logic [15:0] word;

  int    n_chk = 0;
  int    n_err = 0;
  string phase = "R1";

  always #4 clk = ~clk;  // 125 MHz

  pc_word_reg i_pc_word_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .bank_locked_i(locked), .untrace_en_i(ut_en), .untrace_len_i(ut_len),
    .acc_priv_i(priv), .xpc_present_i(xpc), .logger_state_i(state),
    .batt_installed_i(batt), .rtc_on_batt_i(rtc), .temp_alarm_a_i(ta),
    .temp_alarm_b_i(tb), .batt_alarm_i(ba), .tamper_alarm_i(tm),
    .pc_word_o(word)
  );

  // behavioural reference model
  int m_len, m_tgl;
  bit m_al [3];
  bit m_prev [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len = 0; m_tgl = 0;
      foreach (m_al[k]) begin m_al[k] = 0; m_prev[k] = 0; end
    end else begin
      bit c [3];
      bit wok;
      c[0] = tm; c[1] = ba; c[2] = ta || tb;
      wok = wr_en && !locked;
      if (ut_en && priv && ut_len <= 13) m_len = ut_len;
      else if (wok && wr_data[15:11] <= 13) m_len = wr_data[15:11];
      if (wok) m_tgl = wr_data[8];
      for (int k = 0; k < 3; k++) begin
        if (wok) m_al[k] = wr_data[k];
        else if (c[k] && !m_prev[k]) m_al[k] = 1;
        m_prev[k] = c[k];
      end
    end
  end

  function automatic logic [15:0] model_word();
    return {5'(m_len), 1'b1, xpc, 1'(m_tgl), state, batt, rtc,
            m_al[2], m_al[1], m_al[0]};
  endfunction

  always @(negedge clk) begin
    n_chk++;
    if (word !== model_word()) begin
      n_err++;
      $display("FAIL %s (per-cycle model): got %h expected %h", phase, word, model_word());
    end
  end

  task automatic check(string req, logic [15:0] exp);
    n_chk++;
    if (word !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, word, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [15:0] d, logic lk);
    wr_data = d; wr_en = 1'b1; locked = lk;
    tick();
    wr_en = 1'b0; locked = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    check("R1", 16'h0400);
    rst_n = 1'b1;
    tick();
    check("R1", 16'h0400);

    phase = "R2";
    xpc = 1'b1; state = 3'd5; batt = 1'b1; rtc = 1'b1;
    #1 check("R2", 16'h06B8);
    tick();
    xpc = 1'b0; state = '0; batt = 1'b0; rtc = 1'b0;
    #1 check("R2", 16'h0400);

    phase = "R3";  // len 6, toggle 1; junk in fixed/computed bits (R9)
    wr(16'h33F8, 1'b0);
    check("R3", 16'h3500);
    check("R9", 16'h3500);

    phase = "R4";
    wr(16'h6907, 1'b1);
    check("R4", 16'h3500);

    phase = "R5";
    wr(16'h7000, 1'b0);  // len 14 rejected, toggle cleared
    check("R5", 16'h3400);
    wr(16'h6800, 1'b0);  // len 13 accepted
    check("R5", 16'h6C00);

    phase = "R6";
    ut_en = 1'b1; priv = 1'b1; ut_len = 5'd3;
    wr(16'h4900, 1'b1);
    check("R6", 16'h1C00);
    priv = 1'b0; ut_len = 5'd9;
    tick();
    check("R6", 16'h1C00);
    priv = 1'b1; ut_len = 5'd15;
    tick();
    check("R6", 16'h1C00);
    ut_len = 5'd2;
    wr(16'h3900, 1'b0);  // same cycle: untraceable len wins, toggle from write
    ut_en = 1'b0; priv = 1'b0;
    check("R6", 16'h1500);
    wr(16'h1000, 1'b0);
    check("R3", 16'h1400);

    phase = "R7";
    tm = 1'b1; tick();
    check("R7", 16'h1401);
    tick(); tm = 1'b0; tick();
    check("R7", 16'h1401);
    tb = 1'b1; tick();
    check("R7", 16'h1405);
    ba = 1'b1; tick();
    check("R7", 16'h1407);

    phase = "R8";  // clear all while tamper rises in the same cycle
    tm = 1'b1;
    wr(16'h1000, 1'b0);
    check("R8", 16'h1400);
    tick(); tick();
    check("R8", 16'h1400);
    tm = 1'b0; tick();
    tm = 1'b1; tick();
    check("R8", 16'h1401);

    phase = "R4";
    wr(16'h1000, 1'b1);
    check("R4", 16'h1401);

    phase = "R1";
    rst_n = 1'b0; #1;
    check("R1", 16'h0400);
    tick(); rst_n = 1'b1;
    tm = 1'b0; tb = 1'b0; ba = 1'b0;
    tick(); tick();
    check("R1", 16'h0400);

    finish_run();
  end
endmodule